// File: doc/BRIEF.md
# Conditional Call/Return Unit with Stack

This block resolves the two control-flow instructions of a randomized virtual machine: a conditional forward call and a conditional return. Each instruction is 16 bytes long. A branch fires only when operand B, read as an unsigned 32-bit number, is no greater than the second immediate. An instruction that does not fire is a plain move: the result equals operand A and execution carries on with the next instruction.

A call that fires stores a frame on an internal stack. The frame holds operand A and the address of the instruction after the call. The call then jumps forward by a whole number of instructions, between 1 and 128, taken from the first immediate. A return that fires removes the newest frame and jumps to the address it holds. Its result is operand A XOR the saved value. A return with an empty stack never fires. A call with a full stack never fires either, and it sets a sticky overflow flag.

The fetch stage supplies the program counter and operands together with a valid strobe. The results come back one clock later for writeback and redirect. The stack depth and the overflow flag are visible at the ports.

Top module: `callret_unit`

## Requirements
- R1: After a clock edge with `rst_n` low: `out_valid`, `out_taken` and `stack_overflow` are 0, and `stack_depth` is 0.
- R2: The branch condition is `in_b <= in_imm1`, compared unsigned over 32 bits. For example, B = 0xFFFFFFFF with imm1 = 1 never fires.
- R3: When an instruction does not fire: `out_c` equals A, `out_next_pc` equals PC + 16, `out_taken` is 0, and the stack does not change.
- R4: A call that fires (`in_op` = 0, condition true, depth below 16) gives `out_taken` = 1, `out_c` = A and `out_next_pc` = PC + 16 × (`in_imm0` + 1). It raises the depth by one.
- R5: A call whose condition is true while the stack holds 16 frames does not fire and leaves the depth at 16. It sets `stack_overflow`, which stays set until reset.
- R6: A return (`in_op` = 1) with an empty stack never fires, whatever its condition.
- R7: A return that fires gives `out_taken` = 1 and lowers the depth by one. It sets `out_next_pc` to the address after the most recent unreturned call, and `out_c` to A XOR the A that call saved (last in, first out).
- R8: Results appear, with `out_valid` = 1, on the clock edge after the edge that samples `in_valid` = 1. A cycle with `in_valid` = 0 gives `out_valid` = 0 and leaves the depth and the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_op | input | 1 | 0 = call, 1 = return |
| in_pc | input | 32 | Byte address of the instruction |
| in_a | input | 64 | Operand A |
| in_b | input | 32 | Operand B, compared unsigned |
| in_imm0 | input | 7 | Forward distance field, in instructions minus one |
| in_imm1 | input | 32 | Comparison limit |
| out_valid | output | 1 | Results below are valid |
| out_next_pc | output | 32 | Next program counter |
| out_c | output | 64 | Result value |
| out_taken | output | 1 | Branch fired |
| stack_depth | output | 5 | Frames held on the stack |
| stack_overflow | output | 1 | Sticky: a call hit a full stack |

## Verification
The next PC, the result, the taken flag and the valid strobe are registered, so each one is due on the first rising edge after the edge that samples the instruction. The stack depth and the overflow flag change on that same edge. The bench drives on falling edges and samples 1 ns after each rising edge. At that point it compares every output against a queue-based model that was advanced when the instruction was driven. Idle cycles carrying garbage operands, back-to-back nesting, a full 16-frame stack and a long pseudo-random mix are all compared in the same way.

// File: rtl/callret_pkg.sv
`timescale 1ns/1ps
// Shared types for the call/return unit.
package callret_pkg;
    // Instruction select: encoding is visible at the in_op port.
    typedef enum logic {
        OP_CALL = 1'b0,
        OP_RET  = 1'b1
    } cr_op_e;
endpackage

// File: rtl/callret_stack.sv
`timescale 1ns/1ps
// Frame stack: each entry pairs a saved data word with a return address.
// Assumes the caller never asserts push on full or pop on empty; both are
// guarded here anyway. Only the pointer is reset; entries hold stale data.
module callret_stack #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 16,
    parameter int PTR_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] push_data,
    input  logic [ADDR_W-1:0] push_addr,
    output logic [DATA_W-1:0] top_data,
    output logic [ADDR_W-1:0] top_addr,
    output logic              empty,
    output logic              full,
    output logic [PTR_W-1:0]  depth
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] data_mem [DEPTH];
    logic [ADDR_W-1:0] addr_mem [DEPTH];
    logic [PTR_W-1:0]  ptr_q;
    logic [IDX_W-1:0]  wr_idx;
    logic [IDX_W-1:0]  top_idx;

    assign empty   = (ptr_q == '0);
    assign full    = (ptr_q == PTR_W'(DEPTH));
    assign depth   = ptr_q;
    assign wr_idx  = IDX_W'(ptr_q);
    assign top_idx = IDX_W'(ptr_q - 1'b1);
    assign top_data = data_mem[top_idx];
    assign top_addr = addr_mem[top_idx];

    // Pointer: one frame up on push, one frame down on pop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (push && !full)
            ptr_q <= ptr_q + 1'b1;
        else if (pop && !empty)
            ptr_q <= ptr_q - 1'b1;
    end

    // Entry storage: write the new frame at the free slot.
    always_ff @(posedge clk) begin
        if (push && !full) begin
            data_mem[wr_idx] <= push_data;
            addr_mem[wr_idx] <= push_addr;
        end
    end
endmodule

// File: rtl/callret_decide.sv
`timescale 1ns/1ps
// Branch decision: evaluates the unsigned condition and the stack limits,
// and turns them into push, pop, taken and overflow-event strobes.
module callret_decide
    import callret_pkg::*;
#(
    parameter int CMP_W = 32
) (
    input  logic             valid,
    input  cr_op_e           op,
    input  logic [CMP_W-1:0] b_val,
    input  logic [CMP_W-1:0] limit,
    input  logic             stk_empty,
    input  logic             stk_full,
    output logic             push,
    output logic             pop,
    output logic             taken,
    output logic             ovf_evt
);
    logic cond;
    logic is_call;

    // Condition and per-op strobes.
    always_comb begin
        cond    = (b_val <= limit);
        is_call = (op == OP_CALL);
        push    = valid && is_call && cond && !stk_full;
        ovf_evt = valid && is_call && cond && stk_full;
        pop     = valid && !is_call && cond && !stk_empty;
        taken   = push || pop;
    end
endmodule

// File: rtl/callret_target.sv
`timescale 1ns/1ps
// Target and result formation: sequential, forward-call or return target,
// and the result value (A, or A XOR the saved word on a return).
module callret_target #(
    parameter int DATA_W      = 64,
    parameter int ADDR_W      = 32,
    parameter int OFFS_BITS   = 7,
    parameter int INSTR_BYTES = 16
) (
    input  logic [ADDR_W-1:0]    pc,
    input  logic [DATA_W-1:0]    a_val,
    input  logic [OFFS_BITS-1:0] offs,
    input  logic                 push,
    input  logic                 pop,
    input  logic [DATA_W-1:0]    saved_data,
    input  logic [ADDR_W-1:0]    saved_addr,
    output logic [ADDR_W-1:0]    seq_pc,
    output logic [ADDR_W-1:0]    next_pc,
    output logic [DATA_W-1:0]    result
);
    localparam int SHIFT = $clog2(INSTR_BYTES);

    logic [ADDR_W-1:0] slots;
    logic [ADDR_W-1:0] fwd_bytes;

    // Target select and result mix.
    always_comb begin
        seq_pc    = pc + ADDR_W'(INSTR_BYTES);
        slots     = ADDR_W'(offs) + ADDR_W'(1);
        fwd_bytes = slots << SHIFT;
        if (push)
            next_pc = pc + fwd_bytes;
        else if (pop)
            next_pc = saved_addr;
        else
            next_pc = seq_pc;
        result = pop ? (a_val ^ saved_data) : a_val;
    end
endmodule

// File: rtl/callret_unit.sv
`timescale 1ns/1ps
// Conditional call/return unit. Resolves one instruction per cycle and
// registers next PC, result and taken flag one cycle after in_valid.
// Keeps a stack of (operand A, return address) frames and a sticky
// overflow flag for calls that hit a full stack.
module callret_unit
    import callret_pkg::*;
#(
    parameter int DATA_W      = 64,
    parameter int ADDR_W      = 32,
    parameter int CMP_W       = 32,
    parameter int OFFS_BITS   = 7,
    parameter int INSTR_BYTES = 16,
    parameter int DEPTH       = 16,
    localparam int PTR_W      = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_op,
    input  logic [ADDR_W-1:0]    in_pc,
    input  logic [DATA_W-1:0]    in_a,
    input  logic [CMP_W-1:0]     in_b,
    input  logic [OFFS_BITS-1:0] in_imm0,
    input  logic [CMP_W-1:0]     in_imm1,
    output logic                 out_valid,
    output logic [ADDR_W-1:0]    out_next_pc,
    output logic [DATA_W-1:0]    out_c,
    output logic                 out_taken,
    output logic [PTR_W-1:0]     stack_depth,
    output logic                 stack_overflow
);
    logic              push, pop, taken, ovf_evt;
    logic              stk_empty, stk_full;
    logic [DATA_W-1:0] top_data, result;
    logic [ADDR_W-1:0] top_addr, seq_pc, next_pc;
    cr_op_e            op;

    assign op = cr_op_e'(in_op);

    callret_decide #(.CMP_W(CMP_W)) decide_i (
        .valid     (in_valid),
        .op        (op),
        .b_val     (in_b),
        .limit     (in_imm1),
        .stk_empty (stk_empty),
        .stk_full  (stk_full),
        .push      (push),
        .pop       (pop),
        .taken     (taken),
        .ovf_evt   (ovf_evt)
    );

    callret_target #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .OFFS_BITS(OFFS_BITS), .INSTR_BYTES(INSTR_BYTES)
    ) target_i (
        .pc         (in_pc),
        .a_val      (in_a),
        .offs       (in_imm0),
        .push       (push),
        .pop        (pop),
        .saved_data (top_data),
        .saved_addr (top_addr),
        .seq_pc     (seq_pc),
        .next_pc    (next_pc),
        .result     (result)
    );

    callret_stack #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH), .PTR_W(PTR_W)
    ) stack_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .push_data (in_a),
        .push_addr (seq_pc),
        .top_data  (top_data),
        .top_addr  (top_addr),
        .empty     (stk_empty),
        .full      (stk_full),
        .depth     (stack_depth)
    );

    // Output register: capture the resolved instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_next_pc <= '0;
            out_c       <= '0;
            out_taken   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_next_pc <= next_pc;
                out_c       <= result;
                out_taken   <= taken;
            end
        end
    end

    // Sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stack_overflow <= 1'b0;
        else if (ovf_evt)
            stack_overflow <= 1'b1;
    end
endmodule

// File: rtl/callret_unit_chk.sv
`timescale 1ns/1ps
// Checker for callret_unit, attached by bind. Observes ports only.
module callret_unit_chk #(
    parameter int DATA_W      = 64,
    parameter int ADDR_W      = 32,
    parameter int CMP_W       = 32,
    parameter int INSTR_BYTES = 16,
    parameter int DEPTH       = 16,
    parameter int PTR_W       = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_op,
    input logic [ADDR_W-1:0] in_pc,
    input logic [DATA_W-1:0] in_a,
    input logic [CMP_W-1:0]  in_b,
    input logic [CMP_W-1:0]  in_imm1,
    input logic              out_valid,
    input logic [ADDR_W-1:0] out_next_pc,
    input logic [DATA_W-1:0] out_c,
    input logic              out_taken,
    input logic [PTR_W-1:0]  stack_depth,
    input logic              stack_overflow
);
    a_r1_reset: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_taken && !stack_overflow && stack_depth == '0));

    a_r2_cond_false: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_b > in_imm1) |=> (!out_taken && $stable(stack_depth)));

    a_r3_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_taken) |->
        (out_c == $past(in_a) && out_next_pc == $past(in_pc) + ADDR_W'(INSTR_BYTES)));

    a_r4_call_push: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_op && in_b <= in_imm1 && stack_depth < PTR_W'(DEPTH)) |=>
        (out_taken && stack_depth == $past(stack_depth) + 1'b1));

    a_r5_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        stack_depth <= PTR_W'(DEPTH));

    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        stack_overflow |=> stack_overflow);

    a_r6_ret_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op && stack_depth == '0) |=> (!out_taken && stack_depth == '0));

    a_r7_ret_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op && in_b <= in_imm1 && stack_depth != '0) |=>
        (out_taken && stack_depth == $past(stack_depth) - 1'b1));

    a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(stack_depth) && $stable(stack_overflow)));
endmodule

bind callret_unit callret_unit_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CMP_W(CMP_W),
    .INSTR_BYTES(INSTR_BYTES), .DEPTH(DEPTH), .PTR_W(PTR_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_pc(in_pc), .in_a(in_a), .in_b(in_b), .in_imm1(in_imm1),
    .out_valid(out_valid), .out_next_pc(out_next_pc), .out_c(out_c),
    .out_taken(out_taken), .stack_depth(stack_depth),
    .stack_overflow(stack_overflow)
);

// File: tb/callret_unit_tb_top.sv
`timescale 1ns/1ps
// Bench: queue-based reference model, outputs compared after every edge.
module callret_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_op = 1'b0;
    logic [31:0] in_pc = '0;
    logic [63:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic [6:0]  in_imm0 = '0;
    logic [31:0] in_imm1 = '0;
    logic        out_valid, out_taken, stack_overflow;
    logic [31:0] out_next_pc;
    logic [63:0] out_c;
    logic [4:0]  stack_depth;

    callret_unit dut_i (.*);

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit mon_on = 0;

    // Reference model state.
    logic [63:0] m_val[$];
    logic [31:0] m_ret[$];
    bit          m_ovf = 0;
    bit          pend = 0;
    string       pend_tag;
    logic [31:0] e_pc;
    logic [63:0] e_c;
    bit          e_taken;
    logic [31:0] lfsr = 32'h1d2c_3b4a;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Per-edge comparison, 1 ns after the rising edge.
    always @(posedge clk) begin
        #1;
        if (mon_on) begin
            chk("R8 out_valid", {63'd0, out_valid}, {63'd0, pend});
            if (pend) begin
                chk({pend_tag, " next_pc"}, {32'd0, out_next_pc}, {32'd0, e_pc});
                chk({pend_tag, " result"}, out_c, e_c);
                chk({pend_tag, " taken"}, {63'd0, out_taken}, {63'd0, e_taken});
            end
            chk({pend_tag, " depth"}, {59'd0, stack_depth}, 64'(m_val.size()));
            chk("R5 overflow flag", {63'd0, stack_overflow}, {63'd0, m_ovf});
            pend = 0;
            pend_tag = "R8 idle";
        end
    end

    // Drive one instruction at a falling edge and advance the model.
    task automatic issue(input string tag, input bit op, input logic [31:0] pc,
                         input logic [63:0] a, input logic [31:0] b,
                         input logic [6:0] i0, input logic [31:0] i1);
        bit cond;
        @(negedge clk);
        in_valid = 1; in_op = op; in_pc = pc; in_a = a;
        in_b = b; in_imm0 = i0; in_imm1 = i1;
        cond = (b <= i1);
        e_pc = pc + 32'd16; e_c = a; e_taken = 0;
        if (!op) begin
            if (cond && m_val.size() < 16) begin
                m_val.push_back(a); m_ret.push_back(pc + 32'd16);
                e_pc = pc + 32'd16 * ({25'd0, i0} + 32'd1); e_taken = 1;
            end else if (cond) m_ovf = 1;
        end else if (cond && m_val.size() > 0) begin
            e_pc = m_ret.pop_back();
            e_c = a ^ m_val.pop_back();
            e_taken = 1;
        end
        pend = 1; pend_tag = tag;
    endtask

    // Idle cycle with garbage that would fire if it were valid.
    task automatic idle();
        @(negedge clk);
        in_valid = 0; in_op = 0; in_b = 0; in_imm1 = 32'hFFFF_FFFF;
        in_a = 64'hDEAD_BEEF_0BAD_F00D;
        pend = 0; pend_tag = "R8 idle";
    endtask

    task automatic do_reset();
        mon_on = 0;
        @(negedge clk);
        in_valid = 0; rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_val.delete(); m_ret.delete(); m_ovf = 0; pend = 0; pend_tag = "R1";
        @(negedge clk);
        chk("R1 out_valid", {63'd0, out_valid}, 64'd0);
        chk("R1 out_taken", {63'd0, out_taken}, 64'd0);
        chk("R1 overflow", {63'd0, stack_overflow}, 64'd0);
        chk("R1 depth", {59'd0, stack_depth}, 64'd0);
        mon_on = 1;
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x = s;
        x ^= x << 13; x ^= x >> 17; x ^= x << 5;
        return x;
    endfunction

    initial begin
        do_reset();
        // R6: return on empty stack with a true condition.
        issue("R6 ret empty", 1, 32'h0000_1000, 64'h1111, 32'd3, 7'd0, 32'd9);
        // R2: unsigned compare, large B never fires.
        issue("R2 unsigned", 0, 32'h0000_2000, 64'h2222, 32'hFFFF_FFFF, 7'd4, 32'd1);
        // R2: equality fires.
        issue("R2 equal", 0, 32'h0000_3000, 64'hA5A5_0000_0000_0001, 32'd7, 7'd5, 32'd7);
        // R4: maximum forward reach.
        issue("R4 max reach", 0, 32'h0000_4000, 64'hB6B6_0000_0000_0002, 32'd0, 7'h7F, 32'd0);
        idle(); idle();
        // R3: return with false condition while stack is non-empty.
        issue("R3 ret not taken", 1, 32'h0000_5000, 64'h3333, 32'd10, 7'd0, 32'd2);
        // R7: LIFO unwinding.
        issue("R7 ret first", 1, 32'h0000_6000, 64'hFFFF_0000_FFFF_0000, 32'd1, 7'd0, 32'd1);
        issue("R7 ret second", 1, 32'h0000_7000, 64'h0F0F_0F0F_0F0F_0F0F, 32'd0, 7'd0, 32'd5);
        issue("R6 ret drained", 1, 32'h0000_8000, 64'h4444, 32'd0, 7'd0, 32'd5);
        idle();
        // R5: fill the stack, then overflow.
        for (int i = 0; i < 16; i++)
            issue("R4 fill", 0, 32'h0001_0000 + 32'(i) * 32'h100, 64'(i) * 64'h1_0001,
                  32'd1, 7'(i), 32'd2);
        issue("R5 full call", 0, 32'h0002_0000, 64'h5555, 32'd0, 7'd3, 32'd0);
        issue("R5 full call again", 0, 32'h0002_0100, 64'h6666, 32'd0, 7'd3, 32'd0);
        issue("R7 ret after full", 1, 32'h0003_0000, 64'h7777, 32'd0, 7'd0, 32'd0);
        idle(); idle();
        // R1: reset clears the sticky flag and the stack.
        do_reset();
        // Mixed pseudo-random stream.
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r1, r2;
            lfsr = nxt(lfsr); r1 = lfsr;
            lfsr = nxt(lfsr); r2 = lfsr;
            if (r1[31:29] == 3'd0) idle();
            else issue(r1[0] ? "R7 mix ret" : "R4 mix call", r1[0],
                       {r2[27:0], 4'h0}, {r1, r2}, {29'd0, r1[7:5]},
                       r2[30:24], {29'd0, r2[3:1]});
        end
        idle(); idle();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog.
    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog act=running exp=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule